// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

A 32-pin general-purpose I/O port with no direction register. Software drives a pin by writing a one to its bit in the latch-set or latch-clear register. Either write updates the output latch and also turns on the output driver for every bit written as one. The only way to return a pin to input is a write-one-to-clear to the driver-enable register. A fourth register holds a per-pin input-sampling enable. Reading that same address returns the pin levels, which pass through a synchronizer first.

Access uses a simple single-cycle register bus. A write strobe with address and data takes effect at the clock edge. A read strobe captures the selected value into a read-data register, so the data appears on the bus the cycle after the strobe. Three per-pin vectors go straight to the pad cells: driver enable, output level and input-sampling enable.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every pad_oe bit is 0, every pad_out bit is 0, every pad_ie bit is 1 and bus_rdata is 0.
- R2: A write to address 0x108 sets the output latch for each data bit that is 1 and turns on the driver for those pins. Data bits that are 0 change neither the latch nor the enable.
- R3: A write to address 0x10C clears the output latch for each data bit that is 1 and turns on the driver for those pins. Data bits that are 0 change neither the latch nor the enable.
- R4: A write to address 0x100 clears the driver enable for each data bit that is 1 and leaves the output latch unchanged.
- R5: A read strobe at address 0x100 returns the driver-enable vector, and one at 0x108 returns the output latch. The data is on bus_rdata in the cycle after the strobe. In any cycle that follows a cycle without a read strobe, bus_rdata is 0.
- R6: A read at address 0x110 returns the pad input levels after a two-stage synchronizer. A pad change made just before clock edge k is returned by a read strobe sampled at edge k+2 or later, and not by one sampled at edge k+1.
- R7: A write to address 0x110 loads the data word into the input-sampling enable on pad_ie. It changes neither the driver enable nor the output latch.
- R8: Writes to 0x108 and 0x10C in consecutive cycles are both applied, in order. For the same bit, the later write decides the latch value.
- R9: A write to any other address, 0x104 included, changes no state. A read at any other address, 0x10C included, returns 0.
- R10: pad_oe and pad_out show the new register state from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pad_in | input | 32 | Pin levels from the pads |
| pad_oe | output | 32 | Per-pin driver enable |
| pad_out | output | 32 | Per-pin output level |
| pad_ie | output | 32 | Per-pin input-sampling enable |

## Verification
The bench targets these corner cases:
- Writing a pin with the clear register: a design that treated only the set register as a direction change would leave that pin tristated.
- Writing to the driver-enable address: a design that also touched the latch would lose the stored level, so a later re-enable would drive the wrong value.
- Set and clear in back-to-back cycles on overlapping bits, in both orders: this catches a dropped or reordered update.
- Reading the pins one and two edges after a pad change: this pins down the synchronizer depth.
- Reads at the clear address and at holes in the map: a design that decoded too few address bits would return data there.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   // Register byte offsets; software decodes these, so they are fixed.
   localparam int unsigned OFS_DRV_EN  = 'h100;
   localparam int unsigned OFS_LAT_SET = 'h108;
   localparam int unsigned OFS_LAT_CLR = 'h10C;
   localparam int unsigned OFS_PIN     = 'h110;

   // One strobe per write function.
   typedef struct packed {
      logic drv_off;
      logic lat_set;
      logic lat_clr;
      logic ie_load;
   } wr_sel_t;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_DRV  = 2'd1,
      RSEL_LAT  = 2'd2,
      RSEL_PIN  = 2'd3
   } rd_sel_t;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int unsigned AW = 12
) (
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          rd,
   output wr_sel_t       wsel,
   output rd_sel_t       rsel
);

   localparam logic [AW-1:0] A_DRV = AW'(OFS_DRV_EN);
   localparam logic [AW-1:0] A_SET = AW'(OFS_LAT_SET);
   localparam logic [AW-1:0] A_CLR = AW'(OFS_LAT_CLR);
   localparam logic [AW-1:0] A_PIN = AW'(OFS_PIN);

   if (AW < 9) begin : g_bad_aw
      $error("gpio_sc_decode: AW must cover offset 0x110");
   end

   always_comb begin
      wsel         = '0;
      wsel.drv_off = wr && (addr == A_DRV);
      wsel.lat_set = wr && (addr == A_SET);
      wsel.lat_clr = wr && (addr == A_CLR);
      wsel.ie_load = wr && (addr == A_PIN);
   end

   always_comb begin
      rsel = RSEL_NONE;
      if (rd) begin
         unique case (addr)
            A_DRV:   rsel = RSEL_DRV;
            A_SET:   rsel = RSEL_LAT;
            A_PIN:   rsel = RSEL_PIN;
            default: rsel = RSEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_sc_drive.sv
module gpio_sc_drive
   import gpio_sc_pkg::*;
#(
   parameter int unsigned      PINS     = 32,
   parameter logic [PINS-1:0]  IE_RESET = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  wr_sel_t         wsel,
   input  logic [PINS-1:0] wdata,
   output logic [PINS-1:0] drv_en,
   output logic [PINS-1:0] lat,
   output logic [PINS-1:0] ie
);

   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("gpio_sc_drive: PINS must be 1..32");
   end

   logic any_lat_wr;
   assign any_lat_wr = wsel.lat_set | wsel.lat_clr;

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_en[i] <= 1'b0;
            lat[i]    <= 1'b0;
            ie[i]     <= IE_RESET[i];
         end else begin
            if (wsel.drv_off && wdata[i])
               drv_en[i] <= 1'b0;
            else if (any_lat_wr && wdata[i])
               drv_en[i] <= 1'b1;
            if (wsel.lat_set && wdata[i])
               lat[i] <= 1'b1;
            else if (wsel.lat_clr && wdata[i])
               lat[i] <= 1'b0;
            if (wsel.ie_load)
               ie[i] <= wdata[i];
         end
      end
   end

   AST_SET_RAISES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.lat_set |=> ((lat & $past(wdata)) == $past(wdata))); // R2
   AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.lat_set |=> ((drv_en & $past(wdata)) == $past(wdata))); // R2
   AST_CLR_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.lat_clr |=> ((lat & $past(wdata)) == '0)); // R3
   AST_CLR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.lat_clr |=> ((drv_en & $past(wdata)) == $past(wdata))); // R3
   AST_TRI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.drv_off |=> ((drv_en & $past(wdata)) == '0)); // R4
   AST_TRI_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.drv_off |=> $stable(lat)); // R4
   AST_IE_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.ie_load |=> ($stable(lat) && $stable(drv_en))); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel == '0) |=> ($stable(lat) && $stable(drv_en) && $stable(ie))); // R9
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wsel)); // R9

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned PINS   = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d,
   output logic [PINS-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][PINS-1:0] stg;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

   AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stg[1] == $past(stg[0]))); // R6

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned PINS        = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] IE_RESET    = 32'hFFFF_FFFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_wr,
   input  logic [31:0]     bus_wdata,
   input  logic            bus_rd,
   output logic [31:0]     bus_rdata,
   input  logic [PINS-1:0] pad_in,
   output logic [PINS-1:0] pad_oe,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_ie
);

   localparam int unsigned DW = 32;

   if (PINS > DW) begin : g_bad_width
      $error("gpio_setclr_port: PINS exceeds the bus width");
   end

   wr_sel_t         wsel;
   rd_sel_t         rsel;
   logic [PINS-1:0] drv_en, lat, ie, pin_sync;
   logic [DW-1:0]   rd_mux;

   gpio_sc_decode #(.AW(AW)) u_dec (
      .addr (bus_addr),
      .wr   (bus_wr),
      .rd   (bus_rd),
      .wsel (wsel),
      .rsel (rsel)
   );

   gpio_sc_drive #(.PINS(PINS), .IE_RESET(IE_RESET[PINS-1:0])) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .wsel   (wsel),
      .wdata  (bus_wdata[PINS-1:0]),
      .drv_en (drv_en),
      .lat    (lat),
      .ie     (ie)
   );

   gpio_sc_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   always_comb begin
      rd_mux = '0;
      unique case (rsel)
         RSEL_DRV:  rd_mux[PINS-1:0] = drv_en;
         RSEL_LAT:  rd_mux[PINS-1:0] = lat;
         RSEL_PIN:  rd_mux[PINS-1:0] = pin_sync;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end

   assign pad_oe  = drv_en;
   assign pad_out = lat;
   assign pad_ie  = ie;

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R5
   AST_READ_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(OFS_DRV_EN)) |=>
      (bus_rdata[PINS-1:0] == $past(pad_oe))); // R5
   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(OFS_LAT_CLR)) |=> (bus_rdata == '0)); // R9

endmodule

// File: tb/sim_gpio_setclr_port.sv
module sim_gpio_setclr_port;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_oe, pad_out, pad_ie;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] m_oe, m_out, m_ie, m_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_setclr_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model update for one write.
   function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
      case (a)
         12'h100: m_oe = m_oe & ~d;
         12'h108: begin m_out = m_out | d; m_oe = m_oe | d; end
         12'h10C: begin m_out = m_out & ~d; m_oe = m_oe | d; end
         12'h110: m_ie = d;
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] model_rd(input logic [11:0] a);
      case (a)
         12'h100: return m_oe;
         12'h108: return m_out;
         12'h110: return m_pin;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check_pads(input string req);
      chk({req, " pad_oe"},  pad_oe,  m_oe);
      chk({req, " pad_out"}, pad_out, m_out);
      chk({req, " pad_ie"},  pad_ie,  m_ie);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin
      logic [31:0] v, old;
      int seed;
      m_oe = '0; m_out = '0; m_ie = '1; m_pin = '0;
      seed = $urandom(32'h1A2B3C);
      repeat (3) @(negedge clk);
      // R1 reset state
      check_pads("R1");
      chk("R1 rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 set drives and enables only written bits
      wr(12'h108, 32'h0000_00F0);
      check_pads("R2");
      rd_chk("R5 latch read", 12'h108, 32'h0000_00F0);
      rd_chk("R5 enable read", 12'h100, 32'h0000_00F0);
      // R3 clear also enables
      wr(12'h10C, 32'h0000_0F10);
      check_pads("R3");
      chk("R3 latch", pad_out, 32'h0000_00E0);
      chk("R3 enable", pad_oe, 32'h0000_0FF0);
      // R4 tristate clear keeps latch
      wr(12'h100, 32'h0000_00F0);
      check_pads("R4");
      chk("R4 latch kept", pad_out, 32'h0000_00E0);
      // R7 input enable load
      wr(12'h110, 32'h1234_5678);
      check_pads("R7");
      // R9 hole write and reads
      wr(12'h104, 32'hFFFF_FFFF);
      check_pads("R9 hole write");
      wr(12'h000, 32'hFFFF_FFFF);
      check_pads("R9 low write");
      rd_chk("R9 read 0x10C", 12'h10C, 32'h0);
      rd_chk("R9 read 0x104", 12'h104, 32'h0);
      @(negedge clk);
      chk("R5 idle rdata", bus_rdata, 32'h0);

      // R8 back-to-back set then clear, overlap
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h108; bus_wdata = 32'hFF00_0000;
      @(negedge clk);
      chk("R10 after set", pad_out & 32'hFF00_0000, 32'hFF00_0000);
      bus_addr = 12'h10C; bus_wdata = 32'h0F00_0000;
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(12'h108, 32'hFF00_0000);
      model_wr(12'h10C, 32'h0F00_0000);
      check_pads("R8 set-clr");
      // clear then set, overlap
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h10C; bus_wdata = 32'h00FF_0000;
      @(negedge clk);
      bus_addr = 12'h108; bus_wdata = 32'h000F_0000;
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(12'h10C, 32'h00FF_0000);
      model_wr(12'h108, 32'h000F_0000);
      check_pads("R8 clr-set");

      // R6 synchronizer lag
      @(negedge clk);
      old = m_pin;
      pad_in = 32'hA5A5_5A5A;
      m_pin = 32'hA5A5_5A5A;
      rd_chk("R6 one edge old", 12'h110, old);
      rd_chk("R6 two edges new", 12'h110, m_pin);

      // Random phase
      for (int it = 0; it < 600; it++) begin
         int op;
         logic [31:0] d;
         op = $urandom_range(0, 7);
         d  = $urandom();
         case (op)
            0: begin wr(12'h108, d); check_pads("R2 rnd"); end
            1: begin wr(12'h10C, d); check_pads("R3 rnd"); end
            2: begin wr(12'h100, d); check_pads("R4 rnd"); end
            3: begin wr(12'h110, d); check_pads("R7 rnd"); end
            4: begin wr(12'h104 + 12'($urandom_range(0, 1) * 'h10), d); check_pads("R9 rnd"); end
            5: rd_chk("R5 rnd drv", 12'h100, model_rd(12'h100));
            6: rd_chk("R5 rnd lat", 12'h108, model_rd(12'h108));
            default: begin
               @(negedge clk);
               pad_in = d; m_pin = d;
               repeat (2) @(negedge clk);
               rd_chk("R6 rnd pin", 12'h110, model_rd(12'h110));
            end
         endcase
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule